// File: doc/BRIEF.md
# Horizontal Character-Clock Timing Generator

This block paces one scan line of a raster display in units of character clocks. A free-running counter steps on every character-clock enable and wraps after a programmed line length. From the count it derives three horizontal controls: display enable for the active pixel region, a blanking window and a sync pulse. It also raises an end-of-line strobe, which the vertical timing logic downstream uses as its clock enable.

All timing values are static configuration inputs, held by a register block outside this one. The blanking and sync windows each open at a full-width start count. Each closes on a short match against the low counter bits, so either window can run across the end of a line. Sync can be shifted later by a small skew, and display enable can be delayed by a separate small skew. A global sync-enable input masks the sync output without touching any timing state.

Top module: `hline_timer`

## Requirements
- R1: The character counter starts at 0 and advances by one on each cycle with `ce_i` high. After the count equal to `cfg_total_i + 4` it returns to 0, so a line lasts `cfg_total_i + 5` character clocks.
- R2: While `rst_n` is low at a rising edge, the counter clears to 0 and both the blank and sync windows close. After reset, with both skews 0, `char_cnt_o`=0, `blank_o`=0, `hsync_o`=0 and `de_o`=1.
- R3: With display-enable skew 0, `de_o` is high for counts 0 through `cfg_de_end_i` and low for the rest of the line. A value at or above the last count keeps it high all line.
- R4: With display-enable skew k (0..3), `de_o` during count c equals the undelayed display enable of the count k character clocks earlier, including across the line wrap.
- R5: `blank_o` rises at count `cfg_blank_start_i`. It falls at the first later count whose low 6 bits equal `cfg_blank_end_i`. A match at the start count itself is ignored, so the window lasts 1 to 64 character clocks, and 64 when the end field equals the low 6 bits of the start.
- R6: A blank window still open at the wrap stays open into the next line and closes at the first count there whose low 6 bits match the end field.
- R7: A blank start or sync start (after skew) greater than `cfg_total_i + 4` never opens that window.
- R8: The sync window opens at count `cfg_sync_start_i + cfg_sync_skew_i`. It closes at the first later count whose low 5 bits equal `cfg_sync_end_i`, giving 1 to 32 character clocks. `hsync_o` is active high.
- R9: With `sync_en_i` low, `hsync_o` stays low, but the sync window keeps running. Raising `sync_en_i` inside an open window drives `hsync_o` high at once.
- R10: `line_end_o` is high only while `ce_i` is high and the counter holds its last count, that is, for exactly the enable on which the counter wraps to 0.
- R11: With `ce_i` low, the counter and all window and skew state hold their values, and `line_end_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_i | input | 1 | Character-clock enable |
| sync_en_i | input | 1 | Allows the sync output when high |
| cfg_total_i | input | 8 | Line length minus 5 |
| cfg_de_end_i | input | 8 | Last active count |
| cfg_blank_start_i | input | 8 | Count at which blanking opens |
| cfg_blank_end_i | input | 6 | Low-bit match that closes blanking |
| cfg_sync_start_i | input | 8 | Count at which sync opens, before skew |
| cfg_sync_end_i | input | 5 | Low-bit match that closes sync |
| cfg_sync_skew_i | input | 2 | Extra character clocks added to the sync start |
| cfg_de_skew_i | input | 2 | Character-clock delay of display enable |
| char_cnt_o | output | 9 | Current character count |
| de_o | output | 1 | Horizontal display enable |
| blank_o | output | 1 | Horizontal blanking |
| hsync_o | output | 1 | Horizontal sync, active high |
| line_end_o | output | 1 | End-of-line strobe |

## Verification
Some rules are checked by the assertions on every cycle. The counter must hold while the enable is low and return to zero after each strobe. Every opening of a window must fall on its start count, and every closing on a low-bit match that is not the start. A one-step display-enable delay must repeat the previous undelayed value. The bench scenarios are the only place to see the whole-line picture. These include the exact lengths of the 1-, 32- and 64-clock windows, a window carried across the wrap, starts placed beyond the line so they never fire, deeper skew settings, and the sync mask lifted in the middle of a pulse.

// File: rtl/hline_pkg.sv
// Shared constants for the horizontal character-clock timing generator.
// Assumes: field widths follow the default register layout; the block that
// instantiates the generator may override widths through its parameters.
package hline_pkg;
    // Character clocks added to the programmed total to get the real line length.
    localparam int LINE_EXTRA   = 5;
    localparam int DEF_TOT_W    = 8;
    localparam int DEF_BLANK_MW = 6;
    localparam int DEF_SYNC_MW  = 5;
    localparam int DEF_SKEW_W   = 2;
endpackage

// File: rtl/hline_counter.sv
// Character counter for one scan line.
// Counts 0 .. total+LINE_EXTRA-1 on each character-clock enable, then wraps.
// Also gives the next count, so that downstream windows can register
// their state in step with the counter.
// Assumes: total is static while running; a count above the last count
// (after total is lowered) wraps on the next enable.
module hline_counter #(
    parameter int TOT_W = hline_pkg::DEF_TOT_W,
    localparam int CW   = TOT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic [TOT_W-1:0] total_i,
    output logic [CW-1:0]    cnt_o,
    output logic [CW-1:0]    nxt_o,
    output logic             at_last_o
);
    localparam logic [CW-1:0] LAST_OFS = CW'(hline_pkg::LINE_EXTRA - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    // Last count of the line, and the value the counter takes next.
    always_comb begin
        last_cnt  = {1'b0, total_i} + LAST_OFS;
        at_last_o = (cnt_q >= last_cnt);
        nxt_o     = at_last_o ? '0 : cnt_q + 1'b1;
    end

    // Step the counter on each character-clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (ce_i) cnt_q <= nxt_o;
    end

    assign cnt_o = cnt_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> $stable(cnt_q)) else $error("counter moved without enable"); // R11
endmodule

// File: rtl/hline_window.sv
// Start/match window: opens when the counter reaches a full-width start
// count and closes at the first later count whose low MW bits equal the
// end field. The open state is registered, so the output changes in the
// same cycle as the count it belongs to. Start takes priority over the end
// match, so the window is never shorter than one character clock.
// Assumes: start and end are static; the window is closed after reset.
module hline_window #(
    parameter int CW = 9,
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] nxt_i,
    input  logic [CW-1:0] start_i,
    input  logic [MW-1:0] end_i,
    output logic          open_o
);
    logic open_q;

    // Open on reaching the start count; close on a low-bit end match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (ce_i) begin
            if (nxt_i == start_i)
                open_q <= 1'b1;
            else if (open_q && (nxt_i[MW-1:0] == end_i))
                open_q <= 1'b0;
        end
    end

    assign open_o = open_q;

    AST_WIN_OPEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> (cnt_i == start_i)) else $error("window opened off start"); // R5, R8
    AST_WIN_CLOSE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_q) |-> ((cnt_i[MW-1:0] == end_i) && (cnt_i != start_i))) else $error("window closed off match"); // R6
endmodule

// File: rtl/hline_skew.sv
// Character-clock delay line with a selectable tap (0 = no delay).
// Used to skew display enable by 0 .. 2**SKEW_W-1 character clocks.
// Assumes: the tap select is static; stages clear on reset.
module hline_skew #(
    parameter int SKEW_W = hline_pkg::DEF_SKEW_W,
    localparam int DEPTH = (1 << SKEW_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              d_i,
    input  logic [SKEW_W-1:0] sel_i,
    output logic              q_o
);
    logic [DEPTH:1] stage_q;
    logic [DEPTH:0] taps;

    // Shift the undelayed value one stage per character clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (ce_i) begin
            stage_q[1] <= d_i;
            for (int k = 2; k <= DEPTH; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    // Tap 0 is the live input; tap k is k character clocks old.
    always_comb begin
        taps = {stage_q, d_i};
        q_o  = taps[sel_i];
    end

    AST_SKEW_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && sel_i == SKEW_W'(1)) |=> ((sel_i != SKEW_W'(1)) || (q_o == $past(d_i)))) else $error("one-step skew mismatch"); // R4
endmodule

// File: rtl/hline_timer.sv
// Horizontal character-clock timing generator (top).
// Builds display enable, blanking, sync and an end-of-line strobe from one
// line counter. Blank and sync windows close on low-bit matches and may run
// across the line wrap. Sync start is shifted by a skew; display enable is
// delayed by its own skew. sync_en_i masks only the sync output.
// Assumes: configuration inputs are static between resets.
module hline_timer #(
    parameter int TOT_W    = hline_pkg::DEF_TOT_W,
    parameter int BLANK_MW = hline_pkg::DEF_BLANK_MW,
    parameter int SYNC_MW  = hline_pkg::DEF_SYNC_MW,
    parameter int SKEW_W   = hline_pkg::DEF_SKEW_W,
    localparam int CW      = TOT_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_i,
    input  logic                sync_en_i,
    input  logic [TOT_W-1:0]    cfg_total_i,
    input  logic [TOT_W-1:0]    cfg_de_end_i,
    input  logic [TOT_W-1:0]    cfg_blank_start_i,
    input  logic [BLANK_MW-1:0] cfg_blank_end_i,
    input  logic [TOT_W-1:0]    cfg_sync_start_i,
    input  logic [SYNC_MW-1:0]  cfg_sync_end_i,
    input  logic [SKEW_W-1:0]   cfg_sync_skew_i,
    input  logic [SKEW_W-1:0]   cfg_de_skew_i,
    output logic [CW-1:0]       char_cnt_o,
    output logic                de_o,
    output logic                blank_o,
    output logic                hsync_o,
    output logic                line_end_o
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic          at_last;
    logic [CW-1:0] blank_start;
    logic [CW-1:0] sync_start;
    logic          de_raw;
    logic          blank_open;
    logic          sync_open;

    hline_counter #(.TOT_W(TOT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_i      (ce_i),
        .total_i   (cfg_total_i),
        .cnt_o     (cnt),
        .nxt_o     (nxt),
        .at_last_o (at_last)
    );

    // Widen the start counts; the sync start includes its skew.
    always_comb begin
        blank_start = {1'b0, cfg_blank_start_i};
        sync_start  = {1'b0, cfg_sync_start_i} + CW'(cfg_sync_skew_i);
        de_raw      = (cnt <= {1'b0, cfg_de_end_i});
    end

    hline_window #(.CW(CW), .MW(BLANK_MW)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (ce_i),
        .cnt_i   (cnt),
        .nxt_i   (nxt),
        .start_i (blank_start),
        .end_i   (cfg_blank_end_i),
        .open_o  (blank_open)
    );

    hline_window #(.CW(CW), .MW(SYNC_MW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (ce_i),
        .cnt_i   (cnt),
        .nxt_i   (nxt),
        .start_i (sync_start),
        .end_i   (cfg_sync_end_i),
        .open_o  (sync_open)
    );

    hline_skew #(.SKEW_W(SKEW_W)) u_de_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_i  (ce_i),
        .d_i   (de_raw),
        .sel_i (cfg_de_skew_i),
        .q_o   (de_o)
    );

    // Drive the outputs; sync is masked without touching its window.
    always_comb begin
        char_cnt_o = cnt;
        blank_o    = blank_open;
        hsync_o    = sync_en_i & sync_open;
        line_end_o = ce_i & at_last;
    end

    AST_WRAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> (char_cnt_o == '0)) else $error("no wrap after strobe"); // R10
    AST_SYNC_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) && $stable(sync_en_i) |-> (char_cnt_o == sync_start)) else $error("sync rose off start"); // R8
endmodule

// File: tb/sim_hline_timer.sv
// Self-checking bench for hline_timer: a table of line configurations
// walked by one loop, then directed tests for reset and corner cases.
module sim_hline_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       sync_en = 1'b1;
    logic [7:0] total, de_end, bstart, sstart;
    logic [5:0] bend;
    logic [4:0] send;
    logic [1:0] sskew, dskew;
    logic [8:0] cnt;
    logic       de, blank, hsync, lend;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    hline_timer u0 (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sync_en_i(sync_en),
        .cfg_total_i(total), .cfg_de_end_i(de_end),
        .cfg_blank_start_i(bstart), .cfg_blank_end_i(bend),
        .cfg_sync_start_i(sstart), .cfg_sync_end_i(send),
        .cfg_sync_skew_i(sskew), .cfg_de_skew_i(dskew),
        .char_cnt_o(cnt), .de_o(de), .blank_o(blank), .hsync_o(hsync),
        .line_end_o(lend)
    );

    typedef struct packed {
        logic [7:0] tot;
        logic [7:0] dend;
        logic [7:0] bs;
        logic [5:0] be;
        logic [7:0] ss;
        logic [4:0] se;
        logic [1:0] sk;
        logic [1:0] dk;
    } vec_t;

    // Lines: 5-clk blank/6-clk sync; skews; 1-clk windows; starts beyond the
    // line; 64-clk blank with 32-clk sync.
    localparam vec_t VEC [5] = '{
        '{8'd35,  8'd29, 8'd31,  6'd36, 8'd32, 5'd6,  2'd0, 2'd0},
        '{8'd35,  8'd19, 8'd20,  6'd30, 8'd22, 5'd26, 2'd2, 2'd1},
        '{8'd60,  8'd49, 8'd50,  6'd51, 8'd55, 5'd25, 2'd1, 2'd3},
        '{8'd35,  8'd39, 8'd45,  6'd0,  8'd41, 5'd0,  2'd3, 2'd0},
        '{8'd100, 8'd79, 8'd10,  6'd10, 8'd64, 5'd0,  2'd0, 2'd2}
    };

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic load(input vec_t v);
        total = v.tot; de_end = v.dend; bstart = v.bs; bend = v.be;
        sstart = v.ss; send = v.se; sskew = v.sk; dskew = v.dk;
    endtask

    // Hold reset over two edges, release at a falling edge with ce high.
    task automatic do_reset();
        rst_n = 1'b0;
        ce = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int win_len(input int s, input int e, input int mw);
        int m = 1 << mw;
        int l = ((e - (s % m)) + m) % m;
        return (l == 0) ? m : l;
    endfunction

    // Skip two lines, then check every count of the third line.
    // wrap_mode selects the expected blank of the cross-wrap test.
    task automatic run_line(input vec_t v, input bit wrap_mode);
        int len = v.tot + 5;
        int lb = win_len(v.bs, v.be, 6);
        int ss = v.ss + v.sk;
        int ls = win_len(ss, v.se, 5);
        for (int i = 0; i < 3 * len; i++) begin
            if (i >= 2 * len) begin
                int c = i - 2 * len;
                int back = (c - v.dk + len) % len;
                int eb = wrap_mode ? ((c <= 2) || (c >= 36))
                                   : ((c >= v.bs) && (c < v.bs + lb));
                check("R1 count", cnt, c);
                check("R3/R4 display enable", de, back <= v.dend);
                check(wrap_mode ? "R6 blank across wrap" : "R5/R7 blank", blank, eb);
                check("R8/R7 hsync", hsync, (c >= ss) && (c < ss + ls));
                check("R10 line end", lend, c == len - 1);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t w;
        load(VEC[0]);
        @(negedge clk);

        // R2: reset state, sampled with ce low.
        rst_n = 1'b0; ce = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 count", cnt, 0);
        check("R2 blank", blank, 0);
        check("R2 hsync", hsync, 0);
        check("R2 display enable", de, 1);
        check("R2 line end", lend, 0);

        // Table walk: R1, R3, R4, R5, R7, R8, R10.
        for (int k = 0; k < 5; k++) begin
            load(VEC[k]);
            do_reset();
            run_line(VEC[k], 1'b0);
        end

        // R6: blank opened at 36 runs over the wrap and closes at count 3.
        w = VEC[0];
        w.bs = 8'd36; w.be = 6'd3;
        load(w);
        do_reset();
        run_line(w, 1'b1);

        // R9: sync masked, then unmasked inside the open window (32..37).
        load(VEC[0]);
        sync_en = 1'b0;
        do_reset();
        for (int i = 0; i < 114; i++) begin
            check("R9 masked hsync", hsync, 0);
            @(negedge clk);
        end
        check("R9 count at unmask", cnt, 34);
        sync_en = 1'b1;
        #1;
        check("R9 hsync after unmask", hsync, 1);
        repeat (4) @(negedge clk);
        check("R9 hsync after window", hsync, 0);

        // R11 and R10: freeze on the last count, strobe only with enable.
        do_reset();
        repeat (39) @(negedge clk);
        check("R11 count before freeze", cnt, 39);
        ce = 1'b0;
        #1;
        check("R11 no strobe without enable", lend, 0);
        repeat (5) @(negedge clk);
        check("R11 count held", cnt, 39);
        check("R11 blank held", blank, 0);
        check("R11 display enable held", de, 0);
        check("R11 no strobe while frozen", lend, 0);
        ce = 1'b1;
        #1;
        check("R10 strobe on enable", lend, 1);
        @(negedge clk);
        check("R10 wrap to zero", cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule